// File: doc/BRIEF.md
# Indexed Clock and NVRAM Register Port

This block sits between a narrow byte bus and the register space of a real-time clock with battery-backed memory. The bus sees only two addresses. A write to the even address chooses one of 128 byte locations. An access to the odd address then reads or writes that location. Low locations hold the time and alarm fields and four control/status registers. Every location above them is plain storage.

The block does not count time and does not divide the oscillator. An outside counter receives the time fields on `time_out` together with a one-cycle `time_load` strobe. The counter returns advanced fields through `cal_wr`/`cal_data` and reports update progress on `uip_set`/`uip_clr`. An outside divider and alarm comparator raise event pulses on the `flag_*` inputs. The block keeps the control-register side effects: a read-only update-busy bit, a hold bit that freezes the counter view, status bytes that cannot be written, and an event register that clears when read. These drive a single active-high interrupt.

The access port has no back-pressure and no ready signal. Every access that `acc_en` qualifies completes at the next rising edge. Read data appears one cycle later, qualified by `acc_rvalid`.

Top module: `rtcx_regport`

## Requirements
- R1: A write to the even address (`acc_odd`=0) stores `acc_wdata[6:0]` as the location index and ignores bit 7. A read of the even address returns 0xFF.
- R2: A write to the odd address stores the byte at the indexed location. An odd read returns it on `acc_rdata`, and `acc_rvalid` is high in the cycle after the access. This holds for every storage location 14 to 127.
- R3: Location 10 (control A) has a read-only bit 7 (update busy). A write replaces bits 6:0 and keeps bit 7.
- R4: A write to location 11 (control B) with bit 7 (hold) set clears control A bit 7. It also stores bit 4 (update-event enable) as 0.
- R5: Time fields are locations 0, 2, 4, 6, 7, 8 and 9. Writing one while hold is clear pulses `time_load` for one cycle, starting the cycle after the write, with the new byte already on `time_out`. The write does not pulse `time_load` while hold is set. A control B write that clears a set hold bit does pulse it. Writes to the alarm locations 1, 3 and 5 never pulse it.
- R6: Writes to location 12 (event status) and location 13 (status D) have no effect.
- R7: An odd read of location 12 returns its value, then clears it to 0x00 and drops `irq`.
- R8: After reset, control A reads 0x26, B reads 0x02, location 12 reads 0x00, location 13 reads 0x80, and `irq` is low.
- R9: A pulse on `flag_periodic`, `flag_alarm` or `flag_update` sets location 12 bit 6, 5 or 4 respectively, together with bit 7 and `irq`. This happens only when control B bit 6, 5 or 4 enables that source. A pulse from a disabled source leaves both the register and `irq` unchanged.
- R10: An enabled flag pulse in the same cycle as a location 12 read survives the clear. `irq` stays high.
- R11: A `cal_wr` strobe loads `cal_data` into the time fields: byte k, in the order seconds, minutes, hours, weekday, day, month, year, goes to the field at the same byte position of `time_out`. The strobe is ignored while hold is set.
- R12: `uip_set` sets control A bit 7 only while hold is clear. `uip_clr` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access strobe |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_odd | input | 1 | Address bit: 0 index, 1 data |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, registered |
| acc_rvalid | output | 1 | Read data valid |
| uip_set | input | 1 | Counter reports update starting |
| uip_clr | input | 1 | Counter reports update done |
| flag_periodic | input | 1 | Periodic event pulse |
| flag_alarm | input | 1 | Alarm match pulse |
| flag_update | input | 1 | Update-ended pulse |
| cal_wr | input | 1 | Counter write-back strobe |
| cal_data | input | 56 | Advanced time fields, seconds in byte 0 |
| time_out | output | 56 | Stored time fields, seconds in byte 0 |
| alarm_out | output | 24 | Alarm seconds, minutes, hours |
| time_load | output | 1 | Load stored time into counter |
| ctl_a | output | 8 | Control A contents |
| ctl_b | output | 8 | Control B contents |
| irq | output | 1 | Interrupt, active high |

## Verification
Every result is due exactly one cycle after the edge that takes its stimulus: read data and `acc_rvalid`, the `time_load` pulse with its fields, the interrupt after a flag pulse, and the drop of `irq` after a status read. The bench drives inputs on falling edges, lets one rising edge pass, and samples at the next falling edge. Each check therefore sees the register that the single intervening edge wrote. The side-effect checks pair every write with a read back through the odd address. This shows that ignored writes left state alone and that protected bits survived.

// File: rtl/rtcx_pkg.sv
`timescale 1ns/1ps
package rtcx_pkg;
  localparam int IX_SEC    = 0;
  localparam int IX_SEC_AL = 1;
  localparam int IX_MIN    = 2;
  localparam int IX_MIN_AL = 3;
  localparam int IX_HR     = 4;
  localparam int IX_HR_AL  = 5;
  localparam int IX_DOW    = 6;
  localparam int IX_DOM    = 7;
  localparam int IX_MON    = 8;
  localparam int IX_YR     = 9;
  localparam int IX_CTLA   = 10;
  localparam int IX_CTLB   = 11;
  localparam int IX_EVT    = 12;
  localparam int IX_STD    = 13;
  localparam int NFIELD    = 10;
  localparam int NTIME     = 7;
  localparam int NALARM    = 3;

  // bit positions shared by control B and the event register
  localparam int B_HOLD = 7;
  localparam int B_PER  = 6;
  localparam int B_ALM  = 5;
  localparam int B_UPD  = 4;
  localparam int A_BUSY = 7;

  // counter slot of a field location, -1 for alarm locations
  function automatic int time_slot(input int loc);
    case (loc)
      IX_SEC: return 0;
      IX_MIN: return 1;
      IX_HR:  return 2;
      IX_DOW: return 3;
      IX_DOM: return 4;
      IX_MON: return 5;
      IX_YR:  return 6;
      default: return -1;
    endcase
  endfunction

  function automatic int alarm_slot(input int loc);
    case (loc)
      IX_SEC_AL: return 0;
      IX_MIN_AL: return 1;
      IX_HR_AL:  return 2;
      default:   return -1;
    endcase
  endfunction
endpackage

// File: rtl/rtcx_ctrl_regs.sv
`timescale 1ns/1ps
module rtcx_ctrl_regs
  import rtcx_pkg::*;
#(
  parameter logic [7:0] RST_A = 8'h26,
  parameter logic [7:0] RST_B = 8'h02,
  parameter logic [7:0] RST_D = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_a,
  input  logic       wr_b,
  input  logic       rd_evt,
  input  logic [7:0] wdata,
  input  logic       uip_set,
  input  logic       uip_clr,
  input  logic       flag_per,
  input  logic       flag_alm,
  input  logic       flag_upd,
  output logic [7:0] reg_a,
  output logic [7:0] reg_b,
  output logic [7:0] reg_evt,
  output logic [7:0] reg_d,
  output logic       set_exit,
  output logic       irq
);
  logic [2:0] hit;
  logic [7:0] new_flags;

  assign hit = {flag_per & reg_b[B_PER], flag_alm & reg_b[B_ALM], flag_upd & reg_b[B_UPD]};
  assign new_flags = {(|hit), hit, 4'b0000};
  assign set_exit = wr_b & ~wdata[B_HOLD] & reg_b[B_HOLD];
  assign reg_d = RST_D;
  assign irq = reg_evt[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_a <= RST_A;
    end else begin
      if (wr_a) reg_a[6:0] <= wdata[6:0];
      if (wr_b && wdata[B_HOLD]) reg_a[A_BUSY] <= 1'b0;
      else if (uip_clr) reg_a[A_BUSY] <= 1'b0;
      else if (uip_set && !reg_b[B_HOLD]) reg_a[A_BUSY] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_b <= RST_B;
    end else if (wr_b) begin
      reg_b <= wdata[B_HOLD] ? (wdata & ~(8'h01 << B_UPD)) : wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_evt <= 8'h00;
    else reg_evt <= (rd_evt ? 8'h00 : reg_evt) | new_flags;
  end

  p_busy_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a && !wr_b && !uip_set && !uip_clr) |=> (reg_a[A_BUSY] == $past(reg_a[A_BUSY])));
  p_hold_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b && wdata[B_HOLD]) |=> (!reg_b[B_UPD] && !reg_a[A_BUSY]));
  p_evt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !flag_per && !flag_alm && !flag_upd) |=> (reg_evt == 8'h00 && !irq));
  p_flag_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && flag_upd && reg_b[B_UPD]) |=> (irq && reg_evt[B_UPD]));
  p_busy_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (uip_set && reg_b[B_HOLD] && !reg_a[A_BUSY]) |=> !reg_a[A_BUSY]);
endmodule

// File: rtl/rtcx_time_bank.sv
`timescale 1ns/1ps
module rtcx_time_bank
  import rtcx_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int DW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr,
  input  logic [IDX_W-1:0]    host_idx,
  input  logic [DW-1:0]       host_data,
  input  logic                hold,
  input  logic                set_exit,
  input  logic                cal_wr,
  input  logic [NTIME*DW-1:0] cal_data,
  output logic [DW-1:0]       rd_byte,
  output logic [NTIME*DW-1:0] time_out,
  output logic [NALARM*DW-1:0] alarm_out,
  output logic                time_load
);
  logic [DW-1:0] field [NFIELD];
  logic          is_time;

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    localparam int TS = time_slot(g);
    localparam int AS = alarm_slot(g);
    logic sel;
    assign sel = host_wr && (host_idx == IDX_W'(g));
    if (TS >= 0) begin : g_time
      always_ff @(posedge clk) begin
        if (!rst_n) field[g] <= '0;
        else if (sel) field[g] <= host_data;
        else if (cal_wr && !hold) field[g] <= cal_data[TS*DW +: DW];
      end
      assign time_out[TS*DW +: DW] = field[g];
    end else begin : g_alarm
      always_ff @(posedge clk) begin
        if (!rst_n) field[g] <= '0;
        else if (sel) field[g] <= host_data;
      end
      assign alarm_out[AS*DW +: DW] = field[g];
    end
  end

  always_comb begin
    rd_byte = '0;
    is_time = 1'b0;
    for (int i = 0; i < NFIELD; i++) begin
      if (host_idx == IDX_W'(i)) begin
        rd_byte = field[i];
        is_time = (time_slot(i) >= 0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) time_load <= 1'b0;
    else time_load <= (host_wr && is_time && !hold) || set_exit;
  end

  p_quiet_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && hold && !set_exit) |=> !time_load);
  p_cal_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_wr && hold && !host_wr) |=> $stable(time_out));
endmodule

// File: rtl/rtcx_nvram.sv
`timescale 1ns/1ps
module rtcx_nvram #(
  parameter int IDX_W = 7,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             wr,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rd_byte
);
  localparam int DEPTH = 1 << IDX_W;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) mem[idx] <= wdata;
  end

  assign rd_byte = mem[idx];
endmodule

// File: rtl/rtcx_regport.sv
`timescale 1ns/1ps
module rtcx_regport
  import rtcx_pkg::*;
#(
  parameter int         IDX_W = 7,
  parameter int         DW    = 8,
  parameter logic [7:0] RST_A = 8'h26,
  parameter logic [7:0] RST_B = 8'h02,
  parameter logic [7:0] RST_D = 8'h80
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_en,
  input  logic                  acc_we,
  input  logic                  acc_odd,
  input  logic [DW-1:0]         acc_wdata,
  output logic [DW-1:0]         acc_rdata,
  output logic                  acc_rvalid,
  input  logic                  uip_set,
  input  logic                  uip_clr,
  input  logic                  flag_periodic,
  input  logic                  flag_alarm,
  input  logic                  flag_update,
  input  logic                  cal_wr,
  input  logic [NTIME*DW-1:0]   cal_data,
  output logic [NTIME*DW-1:0]   time_out,
  output logic [NALARM*DW-1:0]  alarm_out,
  output logic                  time_load,
  output logic [7:0]            ctl_a,
  output logic [7:0]            ctl_b,
  output logic                  irq
);
  localparam logic [IDX_W-1:0] L_A   = IDX_W'(IX_CTLA);
  localparam logic [IDX_W-1:0] L_B   = IDX_W'(IX_CTLB);
  localparam logic [IDX_W-1:0] L_EVT = IDX_W'(IX_EVT);
  localparam logic [IDX_W-1:0] L_D   = IDX_W'(IX_STD);
  localparam logic [IDX_W-1:0] L_NV  = IDX_W'(IX_STD + 1);

  logic [IDX_W-1:0] idx;
  logic acc_wr, acc_rd, odd_wr;
  logic wr_a, wr_b, rd_evt, fld_wr, nv_wr;
  logic [7:0] reg_a, reg_b, reg_evt, reg_d;
  logic set_exit;
  logic [DW-1:0] fld_byte, nv_byte, rd_sel;

  assign acc_wr = acc_en & acc_we;
  assign acc_rd = acc_en & ~acc_we;
  assign odd_wr = acc_wr & acc_odd;
  assign wr_a   = odd_wr && (idx == L_A);
  assign wr_b   = odd_wr && (idx == L_B);
  assign fld_wr = odd_wr && (idx < L_A);
  assign nv_wr  = odd_wr && (idx >= L_NV);
  assign rd_evt = acc_rd && acc_odd && (idx == L_EVT);

  always_ff @(posedge clk) begin
    if (!rst_n) idx <= '0;
    else if (acc_wr && !acc_odd) idx <= acc_wdata[IDX_W-1:0];
  end

  rtcx_ctrl_regs #(.RST_A(RST_A), .RST_B(RST_B), .RST_D(RST_D)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_a(wr_a), .wr_b(wr_b), .rd_evt(rd_evt),
    .wdata(acc_wdata[7:0]), .uip_set(uip_set), .uip_clr(uip_clr),
    .flag_per(flag_periodic), .flag_alm(flag_alarm), .flag_upd(flag_update),
    .reg_a(reg_a), .reg_b(reg_b), .reg_evt(reg_evt), .reg_d(reg_d),
    .set_exit(set_exit), .irq(irq)
  );

  rtcx_time_bank #(.IDX_W(IDX_W), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n), .host_wr(fld_wr), .host_idx(idx),
    .host_data(acc_wdata), .hold(reg_b[B_HOLD]), .set_exit(set_exit),
    .cal_wr(cal_wr), .cal_data(cal_data), .rd_byte(fld_byte),
    .time_out(time_out), .alarm_out(alarm_out), .time_load(time_load)
  );

  rtcx_nvram #(.IDX_W(IDX_W), .DW(DW)) u_nv (
    .clk(clk), .wr(nv_wr), .idx(idx), .wdata(acc_wdata), .rd_byte(nv_byte)
  );

  always_comb begin
    if (!acc_odd) rd_sel = '1;
    else if (idx < L_A) rd_sel = fld_byte;
    else if (idx == L_A) rd_sel = DW'(reg_a);
    else if (idx == L_B) rd_sel = DW'(reg_b);
    else if (idx == L_EVT) rd_sel = DW'(reg_evt);
    else if (idx == L_D) rd_sel = DW'(reg_d);
    else rd_sel = nv_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_rdata  <= '0;
      acc_rvalid <= 1'b0;
    end else begin
      acc_rvalid <= acc_rd;
      if (acc_rd) acc_rdata <= rd_sel;
    end
  end

  assign ctl_a = reg_a;
  assign ctl_b = reg_b;

  p_even_ff_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !acc_odd) |=> (acc_rdata == '1 && acc_rvalid));
  p_evt_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_wr && idx == L_EVT && !flag_periodic && !flag_alarm && !flag_update) |=> $stable(irq));
  p_irq_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rd_evt) |=> irq);
endmodule

// File: tb/rtcx_regport_test.sv
`timescale 1ns/1ps
module rtcx_regport_test;
  logic clk = 0;
  logic rst_n = 0;
  logic acc_en = 0, acc_we = 0, acc_odd = 0;
  logic [7:0] acc_wdata = 0;
  logic [7:0] acc_rdata;
  logic acc_rvalid;
  logic uip_set = 0, uip_clr = 0;
  logic flag_periodic = 0, flag_alarm = 0, flag_update = 0;
  logic cal_wr = 0;
  logic [55:0] cal_data = 0;
  logic [55:0] time_out;
  logic [23:0] alarm_out;
  logic time_load;
  logic [7:0] ctl_a, ctl_b;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] q;
  logic tl;
  logic rv;

  always #2.5 clk = ~clk;

  rtcx_regport uut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we), .acc_odd(acc_odd),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid),
    .uip_set(uip_set), .uip_clr(uip_clr), .flag_periodic(flag_periodic),
    .flag_alarm(flag_alarm), .flag_update(flag_update), .cal_wr(cal_wr),
    .cal_data(cal_data), .time_out(time_out), .alarm_out(alarm_out),
    .time_load(time_load), .ctl_a(ctl_a), .ctl_b(ctl_b), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic odd, input logic [7:0] d);
    @(negedge clk);
    acc_en = 1; acc_we = we; acc_odd = odd; acc_wdata = d;
    @(negedge clk);
    q = acc_rdata; tl = time_load; rv = acc_rvalid;
    acc_en = 0; acc_we = 0;
  endtask

  task automatic wr(input int i, input logic [7:0] d);
    acc(1, 0, 8'(i));
    acc(1, 1, d);
  endtask

  task automatic rd(input int i);
    acc(1, 0, 8'(i));
    acc(0, 1, 8'h00);
  endtask

  task automatic pulse(input logic p, input logic a, input logic u);
    @(negedge clk);
    flag_periodic = p; flag_alarm = a; flag_update = u;
    @(negedge clk);
    flag_periodic = 0; flag_alarm = 0; flag_update = 0;
  endtask

  task automatic busy(input logic s, input logic c);
    @(negedge clk);
    uip_set = s; uip_clr = c;
    @(negedge clk);
    uip_set = 0; uip_clr = 0;
  endtask

  task automatic cal(input logic [55:0] d);
    @(negedge clk);
    cal_wr = 1; cal_data = d;
    @(negedge clk);
    cal_wr = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R8 reset values
    chk("R8 irq", irq, 0);
    rd(10); chk("R8 ctl A", q, 8'h26);
    rd(11); chk("R8 ctl B", q, 8'h02);
    rd(12); chk("R8 event", q, 8'h00);
    rd(13); chk("R8 status D", q, 8'h80);
    chk("R2 rvalid", rv, 1);

    // R1 even read and 7-bit index
    acc(0, 0, 8'h00); chk("R1 even read", q, 8'hFF);
    acc(1, 0, 8'h94);
    acc(1, 1, 8'h3C);
    rd(20); chk("R1 index bit7 ignored", q, 8'h3C);

    // R2 sweep of storage bytes
    for (int i = 14; i < 128; i++) wr(i, 8'(i) ^ 8'hA5);
    for (int i = 14; i < 128; i++) begin
      rd(i); chk("R2 storage", q, 8'(i) ^ 8'hA5);
    end

    // R3 busy bit read-only, R12 busy set/clear
    wr(10, 8'hFF); rd(10); chk("R3 write keeps busy", q, 8'h7F);
    busy(1, 0); rd(10); chk("R12 busy set", q, 8'hFF);
    wr(10, 8'h26); rd(10); chk("R3 busy survives write", q, 8'hA6);
    busy(0, 1); rd(10); chk("R12 busy clear", q, 8'h26);

    // R4 hold clears busy and masks update enable
    busy(1, 0);
    wr(11, 8'h92);
    rd(11); chk("R4 update enable masked", q, 8'h82);
    rd(10); chk("R4 busy cleared", q, 8'h26);
    chk("R4 ctl_b port", ctl_b, 8'h82);
    busy(1, 0); rd(10); chk("R12 busy blocked by hold", q, 8'h26);

    // R5 / R11 time fields under hold
    wr(0, 8'h45); chk("R5 no load under hold", tl, 0);
    chk("R5 byte stored", time_out[7:0], 8'h45);
    cal(56'h11223344556677);
    chk("R11 writeback blocked", time_out, 56'h45);
    wr(11, 8'h02); chk("R5 load on hold exit", tl, 1);
    wr(2, 8'h30); chk("R5 load on direct write", tl, 1);
    chk("R5 field on load", time_out[15:8], 8'h30);
    wr(1, 8'h59); chk("R5 alarm no load", tl, 0);
    chk("R5 alarm byte", alarm_out[7:0], 8'h59);
    cal(56'h24123107235958);
    chk("R11 writeback", time_out, 56'h24123107235958);
    rd(0); chk("R11 seconds readback", q, 8'h58);
    rd(9); chk("R11 year readback", q, 8'h24);

    // R9 / R6 / R7 update event
    wr(11, 8'h12);
    pulse(0, 0, 1); chk("R9 irq raised", irq, 1);
    wr(12, 8'h00); chk("R6 event write ignored", irq, 1);
    wr(13, 8'h00); rd(13); chk("R6 status D write ignored", q, 8'h80);
    rd(12); chk("R9 update flag", q, 8'h90);
    chk("R7 irq dropped", irq, 0);
    rd(12); chk("R7 cleared", q, 8'h00);

    // R9 disabled sources
    pulse(1, 1, 0); chk("R9 disabled irq", irq, 0);
    rd(12); chk("R9 disabled flags", q, 8'h00);

    // R9 alarm source
    wr(11, 8'h22);
    pulse(0, 1, 0); chk("R9 alarm irq", irq, 1);
    rd(12); chk("R9 alarm flag", q, 8'hA0);

    // R10 flag in the same cycle as a clear
    wr(11, 8'h52);
    pulse(0, 0, 1);
    acc(1, 0, 8'd12);
    @(negedge clk);
    acc_en = 1; acc_we = 0; acc_odd = 1; flag_periodic = 1;
    @(negedge clk);
    q = acc_rdata;
    acc_en = 0; flag_periodic = 0;
    chk("R10 read value", q, 8'h90);
    chk("R10 irq kept", irq, 1);
    rd(12); chk("R10 new flag survived", q, 8'hC0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule